// File: doc/BRIEF.md
# Multiprocessor External Interrupt Router

This block takes a set of level-sensitive external interrupt lines and distributes them to several processor cores. Each line has an enable bit and a software-assert bit. Each line also has a routing mask that chooses which cores see it, so every core can get its own view of the same lines. Each core has a private request port into one shared register bank. Through that port it sets the enables, the software asserts and the routes. The same bank holds a global run-stall register that holds cores in a stalled state, a read-only identity register, and one control bit per core.

Each core's interrupt vector is registered. The routed external lines sit two bit positions above that core's 3-bit inter-processor value, and the two are ORed. That value comes from a separate block on the `ipi_in` port. When several ports request in the same cycle, the lowest-numbered port is served. A port that is not granted keeps its request up and is served in a later cycle. A read returns its data one clock after the grant.

Top module: `irq_router`

## Requirements
- R1: Core c sees external line l only when bit c of line l's routing register is 1. The routing registers sit at offsets 0 to N_LINE-1, one per line, and each stores N_CORE bits.
- R2: The enable register reads at 0x180. A write to 0x180 clears each enable bit written as 1. A write to 0x184 sets each enable bit written as 1. A read of 0x184 returns 0.
- R3: The software-assert register reads at 0x188. A write to 0x188 clears the bits written as 1, and a write to 0x18C sets them. An asserted bit drives its routed line whatever the input level and the enable.
- R4: Core c's vector is (((line_in & enable) | soft_assert) & route_c) << 2, ORed with the 3-bit field ipi_in[3c+2:3c]. Bit 2 therefore carries both IPI bit 2 and line 0.
- R5: After reset every line is enabled, software-assert is 0, every routing register is 1, the control bits are 0 and every interrupt output is 0.
- R6: A read of 0x1A0 returns (N_CORE-1)<<18 ORed with the index of the port that issued the read.
- R7: Offset 0x200 holds one run-stall bit per core, which drives stall_out. It resets to all ones except bit 0.
- R8: Offset 0x220 is private to each port. It stores write data bit 0 only, and reads back as that one bit.
- R9: A read of any other offset returns 0. A write to any other offset, including 0x1A0, changes no state.
- R10: The interrupt outputs change only at a rising clock edge. They reflect the line inputs and any register write accepted in the cycle before that edge.
- R11: gnt is one-hot or zero and goes to the lowest-numbered requesting port. rvalid rises for the granted port in the cycle after a read grant, with rdata valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINE | External interrupt levels, synchronous to clk |
| ipi_in | input | 3*N_CORE | Inter-processor interrupt bits, 3 per core |
| req | input | N_CORE | Per-port access request |
| we | input | N_CORE | Per-port write strobe (1 = write, 0 = read) |
| addr | input | 10*N_CORE | Per-port register offset |
| wdata | input | 32*N_CORE | Per-port write data |
| gnt | output | N_CORE | Per-port grant, combinational from req |
| rvalid | output | N_CORE | Per-port read data valid |
| rdata | output | 32*N_CORE | Per-port read data |
| irq_out | output | (N_LINE+2)*N_CORE | Per-core interrupt vector |
| stall_out | output | N_CORE | Per-core run-stall |

## Verification
The assertions assume that the line and IPI inputs are already synchronous to clk. They also assume that a port's address, strobe and data are steady for the whole cycle in which it is granted. The bench meets both conditions by driving every input at the falling edge. It draws offsets from a pool that mixes mapped registers, routing slots past the last line and unmapped space. Random request vectors often hold more than one port, which exercises the priority rule. A port that loses arbitration drops its request in the random phase and keeps it in the directed phase.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;
    localparam int IPI_W    = 3;
    localparam int ID_SHIFT = 18;

    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 10'h180;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 10'h184;
    localparam logic [ADDR_W-1:0] OFF_SA_CLR = 10'h188;
    localparam logic [ADDR_W-1:0] OFF_SA_SET = 10'h18C;
    localparam logic [ADDR_W-1:0] OFF_ID     = 10'h1A0;
    localparam logic [ADDR_W-1:0] OFF_STALL  = 10'h200;
    localparam logic [ADDR_W-1:0] OFF_CTL    = 10'h220;
endpackage

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] sel,
    output logic          busy
);
    // fixed priority: lowest index wins
    always_comb begin
        gnt  = '0;
        sel  = '0;
        busy = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                sel    = IW'(i);
                busy   = 1'b1;
            end
        end
    end

    p_gnt_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    for (genvar c = 1; c < N; c++) begin : g_prio
        p_gnt_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[c] |-> (req[c-1:0] == '0));
    end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_LINE = 8,
    localparam int IW = $clog2(N_CORE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [IW-1:0]            port,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rd_data,
    output logic [N_LINE-1:0]        en_n,
    output logic [N_LINE-1:0]        sa_n,
    output logic [N_LINE*N_CORE-1:0] route_n,
    output logic [N_LINE*N_CORE-1:0] route_q,
    output logic [N_CORE-1:0]        stall_q
);
    typedef struct packed {
        logic [N_LINE-1:0]             en;
        logic [N_LINE-1:0]             sa;
        logic [N_LINE-1:0][N_CORE-1:0] route;
        logic [N_CORE-1:0]             stall;
        logic [N_CORE-1:0]             ctl;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        r_d     = r_q;
        hit     = 1'b0;
        rd_data = '0;
        // routing slots: one per implemented line
        for (int l = 0; l < N_LINE; l++) begin
            if (addr == ADDR_W'(l)) begin
                hit = 1'b1;
                if (wr_en) r_d.route[l] = wdata[N_CORE-1:0];
                if (rd_en) rd_data = DATA_W'(r_q.route[l]);
            end
        end
        case (addr)
            OFF_EN_CLR: begin
                hit = 1'b1;
                if (wr_en) r_d.en = r_q.en & ~wdata[N_LINE-1:0];
                if (rd_en) rd_data = DATA_W'(r_q.en);
            end
            OFF_EN_SET: begin
                hit = 1'b1;
                if (wr_en) r_d.en = r_q.en | wdata[N_LINE-1:0];
            end
            OFF_SA_CLR: begin
                hit = 1'b1;
                if (wr_en) r_d.sa = r_q.sa & ~wdata[N_LINE-1:0];
                if (rd_en) rd_data = DATA_W'(r_q.sa);
            end
            OFF_SA_SET: begin
                hit = 1'b1;
                if (wr_en) r_d.sa = r_q.sa | wdata[N_LINE-1:0];
            end
            OFF_ID: begin
                if (rd_en) rd_data = (DATA_W'(N_CORE - 1) << ID_SHIFT) | DATA_W'(port);
            end
            OFF_STALL: begin
                hit = 1'b1;
                if (wr_en) r_d.stall = wdata[N_CORE-1:0];
                if (rd_en) rd_data = DATA_W'(r_q.stall);
            end
            OFF_CTL: begin
                hit = 1'b1;
                for (int c = 0; c < N_CORE; c++) begin
                    if (port == IW'(c)) begin
                        if (wr_en) r_d.ctl[c] = wdata[0];
                        if (rd_en) rd_data = DATA_W'(r_q.ctl[c]);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en    <= '1;
            r_q.sa    <= '0;
            r_q.stall <= ~N_CORE'(1);
            r_q.ctl   <= '0;
            for (int l = 0; l < N_LINE; l++) r_q.route[l] <= N_CORE'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign en_n    = r_d.en;
    assign sa_n    = r_d.sa;
    assign route_n = r_d.route;
    assign route_q = r_q.route;
    assign stall_q = r_q.stall;

    p_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_EN_CLR) |=> ((r_q.en & $past(wdata[N_LINE-1:0])) == '0));
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_EN_SET) |=>
            ((r_q.en & $past(wdata[N_LINE-1:0])) == $past(wdata[N_LINE-1:0])));
    p_sa_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SA_CLR) |=> ((r_q.sa & $past(wdata[N_LINE-1:0])) == '0));
    p_sa_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SA_SET) |=>
            ((r_q.sa & $past(wdata[N_LINE-1:0])) == $past(wdata[N_LINE-1:0])));
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(r_q));
endmodule

// File: rtl/irq_router_map.sv
module irq_router_map
    import irq_router_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_LINE = 8,
    localparam int OUT_W = N_LINE + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINE-1:0]        line_in,
    input  logic [N_CORE*IPI_W-1:0]  ipi_in,
    input  logic [N_LINE-1:0]        en_n,
    input  logic [N_LINE-1:0]        sa_n,
    input  logic [N_LINE*N_CORE-1:0] route_n,
    output logic [N_CORE*OUT_W-1:0]  irq_out
);
    logic [N_LINE-1:0]             live;
    logic [N_CORE-1:0][N_LINE-1:0] ext;
    logic [N_CORE*OUT_W-1:0]       irq_d, irq_q;
    logic                          armed_q;

    always_comb begin
        live = (line_in & en_n) | sa_n;
        for (int c = 0; c < N_CORE; c++) begin
            for (int l = 0; l < N_LINE; l++) ext[c][l] = live[l] & route_n[l*N_CORE + c];
            irq_d[c*OUT_W +: OUT_W] = {ext[c], 2'b00} | OUT_W'(ipi_in[c*IPI_W +: IPI_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            irq_q   <= irq_d;
            armed_q <= 1'b1;
        end
    end

    assign irq_out = irq_q;

    for (genvar c = 0; c < N_CORE; c++) begin : g_chk
        p_ipi_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> (irq_q[c*OUT_W +: 2] == $past(ipi_in[c*IPI_W +: 2])));
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_LINE = 8,
    localparam int IW    = $clog2(N_CORE),
    localparam int OUT_W = N_LINE + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINE-1:0]         line_in,
    input  logic [N_CORE*IPI_W-1:0]   ipi_in,
    input  logic [N_CORE-1:0]         req,
    input  logic [N_CORE-1:0]         we,
    input  logic [N_CORE*ADDR_W-1:0]  addr,
    input  logic [N_CORE*DATA_W-1:0]  wdata,
    output logic [N_CORE-1:0]         gnt,
    output logic [N_CORE-1:0]         rvalid,
    output logic [N_CORE*DATA_W-1:0]  rdata,
    output logic [N_CORE*OUT_W-1:0]   irq_out,
    output logic [N_CORE-1:0]         stall_out
);
    logic [IW-1:0]            sel;
    logic                     busy, wr_en, rd_en;
    logic [ADDR_W-1:0]        sel_addr;
    logic [DATA_W-1:0]        sel_wdata, rd_data;
    logic [N_LINE-1:0]        en_n, sa_n;
    logic [N_LINE*N_CORE-1:0] route_n, route_q;
    logic [N_CORE-1:0]        rvalid_d, rvalid_q;
    logic [N_CORE*DATA_W-1:0] rdata_d, rdata_q;

    irq_router_arb #(.N(N_CORE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .sel(sel), .busy(busy)
    );

    assign sel_addr  = addr[sel*ADDR_W +: ADDR_W];
    assign sel_wdata = wdata[sel*DATA_W +: DATA_W];
    assign wr_en     = busy & we[sel];
    assign rd_en     = busy & ~we[sel];

    irq_router_regs #(.N_CORE(N_CORE), .N_LINE(N_LINE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port(sel),
        .addr(sel_addr), .wdata(sel_wdata), .rd_data(rd_data),
        .en_n(en_n), .sa_n(sa_n), .route_n(route_n), .route_q(route_q),
        .stall_q(stall_out)
    );

    irq_router_map #(.N_CORE(N_CORE), .N_LINE(N_LINE)) u_map (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .ipi_in(ipi_in),
        .en_n(en_n), .sa_n(sa_n), .route_n(route_n), .irq_out(irq_out)
    );

    // read response: one clock after the grant
    always_comb begin
        rvalid_d = gnt & ~we;
        rdata_d  = rdata_q;
        if (rd_en) rdata_d[sel*DATA_W +: DATA_W] = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= '0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rvalid_d;
            rdata_q  <= rdata_d;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

    p_rvalid_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rvalid));

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        for (genvar l = 1; l < N_LINE; l++) begin : g_line
            p_route_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[c*OUT_W + l + 2] |-> route_q[l*N_CORE + c]);
        end
    end
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
    localparam int NC = 4;
    localparam int NL = 8;
    localparam int OW = NL + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NL-1:0]        line_in = '0;
    logic [NC*3-1:0]      ipi_in = '0;
    logic [NC-1:0]        req = '0, we = '0;
    logic [NC*10-1:0]     addr = '0;
    logic [NC*32-1:0]     wdata = '0;
    logic [NC-1:0]        gnt, rvalid, stall_out;
    logic [NC*32-1:0]     rdata;
    logic [NC*OW-1:0]     irq_out;

    irq_router #(.N_CORE(NC), .N_LINE(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .ipi_in(ipi_in),
        .req(req), .we(we), .addr(addr), .wdata(wdata), .gnt(gnt),
        .rvalid(rvalid), .rdata(rdata), .irq_out(irq_out), .stall_out(stall_out)
    );

    always #10 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_tag = "";

    // bench stimulus state
    logic [NC-1:0]  b_req, b_we;
    logic [9:0]     b_addr [NC];
    logic [31:0]    b_wdata [NC];
    logic [NL-1:0]  b_line;
    logic [NC*3-1:0] b_ipi;

    // reference model
    logic [NL-1:0]  m_en, m_sa;
    logic [NC-1:0]  m_route [NL];
    logic [NC-1:0]  m_stall, m_ctl;
    logic [NC*OW-1:0] prev_irq;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = '1; m_sa = '0; m_stall = 4'b1110; m_ctl = '0;
        for (int l = 0; l < NL; l++) m_route[l] = 4'b0001;
        prev_irq = '0;
    endtask

    function automatic logic [31:0] model_read(input int p, input logic [9:0] a);
        if (a < 10'(NL)) return 32'(m_route[a[2:0]]);
        case (a)
            10'h180: return 32'(m_en);
            10'h188: return 32'(m_sa);
            10'h1A0: return (32'(NC - 1) << 18) | 32'(p);
            10'h200: return 32'(m_stall);
            10'h220: return 32'(m_ctl[p]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int p, input logic [9:0] a, input logic [31:0] d);
        if (a < 10'(NL)) m_route[a[2:0]] = d[NC-1:0];
        else case (a)
            10'h180: m_en = m_en & ~d[NL-1:0];
            10'h184: m_en = m_en | d[NL-1:0];
            10'h188: m_sa = m_sa & ~d[NL-1:0];
            10'h18C: m_sa = m_sa | d[NL-1:0];
            10'h200: m_stall = d[NC-1:0];
            10'h220: m_ctl[p] = d[0];
            default: ;
        endcase
    endtask

    function automatic logic [OW-1:0] model_irq(input int c);
        logic [NL-1:0] live, ext;
        live = (b_line & m_en) | m_sa;
        for (int l = 0; l < NL; l++) ext[l] = live[l] & m_route[l][c];
        return {ext, 2'b00} | OW'(b_ipi[c*3 +: 3]);
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        if (a < 10'(NL)) return "R1";
        case (a)
            10'h180, 10'h184: return "R2";
            10'h188, 10'h18C: return "R3";
            10'h1A0: return "R6";
            10'h200: return "R7";
            10'h220: return "R8";
            default: return "R9";
        endcase
    endfunction

    // one bus cycle: drive at falling edge, check grant, then outputs after the rising edge
    task automatic tick();
        logic [NC-1:0]    exp_g;
        logic [NC*OW-1:0] exp_irq;
        int               gp;
        bit               rd;
        logic [31:0]      exp_rd;
        string            rtag;
        req = b_req; we = b_we; line_in = b_line; ipi_in = b_ipi;
        for (int c = 0; c < NC; c++) begin
            addr[c*10 +: 10]  = b_addr[c];
            wdata[c*32 +: 32] = b_wdata[c];
        end
        #1;
        exp_g = '0; gp = -1; rd = 0; exp_rd = '0; rtag = "R9";
        for (int c = NC - 1; c >= 0; c--) if (b_req[c]) gp = c;
        if (gp >= 0) exp_g[gp] = 1'b1;
        chk(gnt == exp_g, "R11 grant", 64'(gnt), 64'(exp_g));
        chk(irq_out == prev_irq, "R10 pre-edge", 64'(irq_out), 64'(prev_irq));
        if (gp >= 0) begin
            if (b_we[gp]) model_write(gp, b_addr[gp], b_wdata[gp]);
            else begin
                rd = 1; exp_rd = model_read(gp, b_addr[gp]);
                rtag = (cur_tag != "") ? cur_tag : tag_of(b_addr[gp]);
            end
        end
        for (int c = 0; c < NC; c++) exp_irq[c*OW +: OW] = model_irq(c);
        @(posedge clk); @(negedge clk);
        for (int c = 0; c < NC; c++)
            chk(irq_out[c*OW +: OW] == exp_irq[c*OW +: OW],
                (cur_tag != "") ? cur_tag : "R1 irq",
                64'(irq_out[c*OW +: OW]), 64'(exp_irq[c*OW +: OW]));
        chk(stall_out == m_stall, "R7 stall", 64'(stall_out), 64'(m_stall));
        chk(rvalid == (rd ? exp_g : '0), "R11 rvalid", 64'(rvalid), 64'(rd ? exp_g : '0));
        if (rd) chk(rdata[gp*32 +: 32] == exp_rd, rtag, 64'(rdata[gp*32 +: 32]), 64'(exp_rd));
        prev_irq = exp_irq;
    endtask

    task automatic idle();
        b_req = '0; b_we = '0;
        for (int c = 0; c < NC; c++) begin b_addr[c] = '0; b_wdata[c] = '0; end
    endtask

    task automatic access(input int p, input bit w, input logic [9:0] a, input logic [31:0] d);
        idle();
        b_req[p] = 1'b1; b_we[p] = w; b_addr[p] = a; b_wdata[p] = d;
        tick();
    endtask

    function automatic logic [9:0] pick_addr();
        case ($urandom_range(0, 11))
            0, 1, 2: return 10'($urandom_range(0, NL - 1));
            3:  return 10'($urandom_range(NL, 31));
            4:  return 10'h180;
            5:  return 10'h184;
            6:  return 10'h188;
            7:  return 10'h18C;
            8:  return 10'h1A0;
            9:  return 10'h200;
            10: return 10'h220;
            default: return 10'h300 | 10'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        idle(); b_line = '0; b_ipi = '0;
        repeat (3) @(negedge clk);
        // R5: outputs during and right after reset
        chk(irq_out == '0, "R5 irq reset", 64'(irq_out), 64'h0);
        chk(stall_out == 4'b1110, "R5 stall reset", 64'(stall_out), 64'hE);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R5";
        access(0, 0, 10'h000, 0);
        access(1, 0, 10'h007, 0);
        access(2, 0, 10'h180, 0);
        access(3, 0, 10'h188, 0);
        access(0, 0, 10'h200, 0);
        access(3, 0, 10'h220, 0);
        cur_tag = "";

        // R1: all lines high go to core 0 only, then reroute line 3 to cores 1 and 2
        b_line = '1; idle(); tick();
        access(0, 1, 10'h003, 32'h6);
        // R2: clear then set enable of line 3, read both addresses
        access(1, 1, 10'h180, 32'h8);
        access(1, 0, 10'h180, 0);
        access(2, 1, 10'h184, 32'h8);
        access(2, 0, 10'h184, 0);
        // R3: software assert drives a disabled, low line
        b_line = '0;
        access(0, 1, 10'h180, 32'hFF);
        access(3, 1, 10'h18C, 32'h09);
        access(3, 0, 10'h188, 0);
        access(3, 1, 10'h188, 32'h01);
        access(0, 1, 10'h184, 32'hFF);
        access(3, 1, 10'h188, 32'hFF);
        // R4: IPI bits and the shared bit 2
        cur_tag = "R4";
        b_ipi = 12'b100_011_101_100; b_line = 8'h01; idle(); tick();
        b_line = 8'h00; idle(); tick();
        b_ipi = '0; idle(); tick();
        cur_tag = "";
        // R6: identity from each port
        for (int p = 0; p < NC; p++) access(p, 0, 10'h1A0, 0);
        // R8: per-port control bit
        access(1, 1, 10'h220, 32'hFFFF_FFFF);
        access(1, 0, 10'h220, 0);
        access(0, 0, 10'h220, 0);
        // R7: run-stall update
        access(2, 1, 10'h200, 32'hFFFF_FFF5);
        access(2, 0, 10'h200, 0);
        // R9: writes to identity and unmapped space are dropped
        access(0, 1, 10'h1A0, 32'hFFFF_FFFF);
        access(0, 1, 10'h3F0, 32'hFFFF_FFFF);
        access(0, 1, 10'h01F, 32'hF);
        access(0, 0, 10'h3F0, 0);
        access(0, 0, 10'h01F, 0);
        access(1, 0, 10'h1A0, 0);
        // R11: contention, the losing port holds and is served next
        idle();
        b_req = 4'b1010; b_addr[1] = 10'h180; b_addr[3] = 10'h200; tick();
        b_req = 4'b1000; tick();
        // R10: a line edge appears only after the next rising edge
        b_line = 8'hA5; idle(); tick();
        b_line = 8'h5A; idle(); tick();

        // constrained random phase
        for (int n = 0; n < 400; n++) begin
            b_req = NC'($urandom());
            b_we  = NC'($urandom());
            for (int c = 0; c < NC; c++) begin
                b_addr[c]  = pick_addr();
                b_wdata[c] = $urandom();
            end
            if ($urandom_range(0, 3) == 0) b_line = NL'($urandom());
            if ($urandom_range(0, 3) == 0) b_ipi  = (NC*3)'($urandom());
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule